// File: doc/BRIEF.md
# Oscillator Tap Modulation Sequencer

This block sits beside a tapped ring or delay-line oscillator and, on every oscillator cycle, names the tap the oscillator should run on next. A coarse tap value sets the base period, and a modulation value says how many cycles of each frame should use the next tap up. Dithering between two adjacent taps gives an average period that lies between the two coarse steps. The block runs in repeating frames whose length is two to the power of the modulation width, which is 32 cycles by default.

A phase accumulator spreads the upper-tap cycles across the frame. The modulation value is added on every cycle, and each carry out of the accumulator selects the upper tap for that cycle. Settings are taken only at the frame boundary, so a frame never blends two settings. A synchronous reset starts a fresh frame. The oscillator and any frequency measurement live outside this block.

Top module: `tapmod_seq`

## Requirements
- R1: With constant inputs, the tap sequence repeats exactly every 32 cycles. Frame cycle 0 is the first cycle after reset is released.
- R2: In every frame, exactly M cycles use the upper tap and 32−M use the base tap, where M is the frame's modulation value.
- R3: When the modulation value is 0, every cycle of the frame outputs the base tap.
- R4: Frame cycle i (0..31) uses the upper tap exactly when floor((i+1)·M/32) > floor(i·M/32). As a result, the cyclic gaps between upper-tap cycles differ by at most one.
- R5: The upper tap is the base tap plus one, clamped to 31. With base tap 31, the output stays at 31 on every cycle.
- R6: Tap and modulation inputs are sampled only at the clock edge that ends frame cycle 31, and they govern the whole next frame. Changes at any other time have no effect.
- R7: While reset is high, the block samples tap and modulation for the first frame. When reset is released, frame cycle 0 begins with the accumulator cleared, even if reset arrived in the middle of a frame.
- R8: The output is always either the frame's base tap or its upper tap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| tap_in | input | 5 | Requested coarse tap, 0..31 |
| mod_in | input | 5 | Requested upper-tap count per frame, 0..31 |
| tap_out | output | 5 | Tap to apply on the current cycle |

## Verification
Whenever the modulation value is non-zero, frame cycle 31 always carries. That same cycle is also the one that loads the next frame's settings, so the upper-tap pick and the settings reload fall in the same cycle. The bench changes tap and modulation during cycle 31. It requires that cycle 31 still show the old upper tap and that cycle 0 follow the new settings. The second collision is a reset that lands mid-frame while the accumulator holds a non-zero phase. The bench judges this by requiring that the following frame match the pattern expected from a cleared accumulator.

// File: rtl/tapmod_pkg.sv
package tapmod_pkg;
   localparam int unsigned DEF_TAP_W = 5;
   localparam int unsigned DEF_MOD_W = 5;

   typedef enum logic {
      PICK_BASE  = 1'b0,
      PICK_UPPER = 1'b1
   } tap_pick_e;
endpackage

// File: rtl/tapmod_frame_ctr.sv
module tapmod_frame_ctr #(
   parameter int unsigned MOD_W = tapmod_pkg::DEF_MOD_W
) (
   input  logic clk,
   input  logic rst,
   output logic frame_first,
   output logic frame_last
);
   localparam int unsigned FRAME_LEN = 2 ** MOD_W;
   localparam logic [MOD_W-1:0] LAST_IDX = MOD_W'(FRAME_LEN - 1);

   logic [MOD_W-1:0] idx_q;

   always_ff @(posedge clk) begin
      if (rst) idx_q <= '0;
      else     idx_q <= idx_q + 1'b1;
   end

   assign frame_first = (idx_q == '0);
   assign frame_last  = (idx_q == LAST_IDX);

   // R1: the counter wraps to the frame start after its last cycle
   p_frame_wrap_r1: assert property (@(posedge clk) disable iff (rst)
      frame_last |=> frame_first);

   // R1: inside a frame the counter advances by one each cycle
   p_frame_step_r1: assert property (@(posedge clk) disable iff (rst)
      !frame_last |=> (idx_q == $past(idx_q) + 1'b1));
endmodule

// File: rtl/tapmod_accum.sv
module tapmod_accum #(
   parameter int unsigned MOD_W = tapmod_pkg::DEF_MOD_W
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   frame_first,
   input  logic [MOD_W-1:0]       mod_val,
   output tapmod_pkg::tap_pick_e  pick
);
   import tapmod_pkg::*;

   logic [MOD_W-1:0] phase_q;
   logic [MOD_W:0]   sum;

   assign sum  = {1'b0, phase_q} + {1'b0, mod_val};
   assign pick = tap_pick_e'(sum[MOD_W]);

   // Never cleared except by reset: a full frame of equal additions wraps it back to zero.
   always_ff @(posedge clk) begin
      if (rst) phase_q <= '0;
      else     phase_q <= sum[MOD_W-1:0];
   end

   // R2/R4: every frame starts from zero phase, so each frame carries exactly mod_val times
   p_phase_zero_r4: assert property (@(posedge clk) disable iff (rst)
      frame_first |-> (phase_q == '0));
endmodule

// File: rtl/tapmod_tap_sel.sv
module tapmod_tap_sel #(
   parameter int unsigned TAP_W   = tapmod_pkg::DEF_TAP_W,
   parameter int unsigned TAP_MAX = (2 ** TAP_W) - 1
) (
   input  logic [TAP_W-1:0]       base_tap,
   input  tapmod_pkg::tap_pick_e  pick,
   output logic [TAP_W-1:0]       tap_code
);
   import tapmod_pkg::*;

   localparam int unsigned FULL_MAX = (2 ** TAP_W) - 1;

   logic [TAP_W-1:0] upper;

   generate
      if (TAP_MAX == FULL_MAX) begin : g_full_range
         logic [TAP_W:0] inc;
         assign inc   = {1'b0, base_tap} + 1'b1;
         assign upper = inc[TAP_W] ? base_tap : inc[TAP_W-1:0];
      end else begin : g_limited_range
         assign upper = (base_tap >= TAP_W'(TAP_MAX)) ? base_tap : base_tap + 1'b1;
      end
   endgenerate

   assign tap_code = (pick == PICK_UPPER) ? upper : base_tap;
endmodule

// File: rtl/tapmod_seq.sv
module tapmod_seq #(
   parameter int unsigned TAP_W   = tapmod_pkg::DEF_TAP_W,
   parameter int unsigned MOD_W   = tapmod_pkg::DEF_MOD_W,
   parameter int unsigned TAP_MAX = (2 ** TAP_W) - 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [TAP_W-1:0] tap_in,
   input  logic [MOD_W-1:0] mod_in,
   output logic [TAP_W-1:0] tap_out
);
   import tapmod_pkg::*;

   generate
      if (TAP_W < 1 || TAP_W > 16) begin : g_bad_tap_w
         $error("tapmod_seq: TAP_W must lie in 1..16");
      end
      if (MOD_W < 1 || MOD_W > 16) begin : g_bad_mod_w
         $error("tapmod_seq: MOD_W must lie in 1..16");
      end
      if (TAP_MAX > (2 ** TAP_W) - 1) begin : g_bad_tap_max
         $error("tapmod_seq: TAP_MAX exceeds the tap code range");
      end
   endgenerate

   logic             frame_first;
   logic             frame_last;
   logic [TAP_W-1:0] tap_q;
   logic [MOD_W-1:0] mod_q;
   tap_pick_e        pick;

   // Settings are loaded during reset and at the edge that closes a frame.
   always_ff @(posedge clk) begin
      if (rst || frame_last) begin
         tap_q <= tap_in;
         mod_q <= mod_in;
      end
   end

   tapmod_frame_ctr #(.MOD_W(MOD_W)) u_frame (
      .clk         (clk),
      .rst         (rst),
      .frame_first (frame_first),
      .frame_last  (frame_last)
   );

   tapmod_accum #(.MOD_W(MOD_W)) u_accum (
      .clk         (clk),
      .rst         (rst),
      .frame_first (frame_first),
      .mod_val     (mod_q),
      .pick        (pick)
   );

   tapmod_tap_sel #(.TAP_W(TAP_W), .TAP_MAX(TAP_MAX)) u_sel (
      .base_tap (tap_q),
      .pick     (pick),
      .tap_code (tap_out)
   );

   // Checker counter: upper-tap cycles seen so far in the current frame.
   logic [MOD_W:0] upper_seen;
   always_ff @(posedge clk) begin
      if (rst || frame_last) upper_seen <= '0;
      else if (pick == PICK_UPPER) upper_seen <= upper_seen + 1'b1;
   end

   // R2: frame total of upper-tap cycles equals the modulation value
   p_frame_count_r2: assert property (@(posedge clk) disable iff (rst)
      frame_last |-> ((upper_seen + {{MOD_W{1'b0}}, pick}) == {1'b0, mod_q}));

   // R3: zero modulation never picks the upper tap
   p_zero_mod_base_r3: assert property (@(posedge clk) disable iff (rst)
      (mod_q == '0) |-> (tap_out == tap_q));

   // R5: at the top tap the output cannot climb
   p_clamp_top_r5: assert property (@(posedge clk) disable iff (rst)
      (tap_q == TAP_W'(TAP_MAX)) |-> (tap_out == tap_q));

   // R6: settings hold for the whole frame
   p_hold_midframe_r6: assert property (@(posedge clk) disable iff (rst)
      !frame_last |=> ($stable(tap_q) && $stable(mod_q)));

   // R8: output is the base tap or one above it
   p_tap_adjacent_r8: assert property (@(posedge clk) disable iff (rst)
      ({1'b0, tap_out} == {1'b0, tap_q}) || ({1'b0, tap_out} == {1'b0, tap_q} + 1'b1));
endmodule

// File: tb/tb_tapmod_seq.sv
module tb_tapmod_seq;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [4:0] tap_in = 5'd0;
   logic [4:0] mod_in = 5'd0;
   logic [4:0] tap_out;

   int compared = 0;
   int mismatched = 0;
   int last_pat [32];
   int prev_pat [32];

   always #5 clk = ~clk;

   tapmod_seq dut (
      .clk     (clk),
      .rst     (rst),
      .tap_in  (tap_in),
      .mod_in  (mod_in),
      .tap_out (tap_out)
   );

   task automatic check(input bit ok, input string tag, input string what,
                        input int act, input int exp);
      compared++;
      if (!ok) begin
         mismatched++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   function automatic bit is_upper(input int i, input int m);
      return ((i + 1) * m) / 32 != (i * m) / 32;
   endfunction

   function automatic int upper_of(input int t);
      return (t == 31) ? 31 : t + 1;
   endfunction

   // Sync reset with settings for the first frame; returns positioned at frame cycle 0.
   task automatic do_reset(input int t, input int m);
      rst = 1'b1; tap_in = 5'(t); mod_in = 5'(m);
      @(negedge clk);
      @(negedge clk);
      rst = 1'b0;
   endtask

   // Checks one frame; starts and ends at frame cycle 0 (negedge).
   task automatic run_frame(input int et, input int em, input int nt, input int nm,
                            input bit mid, input int mt, input int mm, input string tag);
      int ups = 0;
      int bad = 0;
      int first = -1;
      int prevp = -1;
      int gmin = 99;
      int gmax = 0;
      for (int i = 0; i < 32; i++) begin
         int exp;
         #1;
         exp = is_upper(i, em) ? upper_of(et) : et;
         last_pat[i] = int'(tap_out);
         check(int'(tap_out) == exp, tag, $sformatf("tap at cycle %0d", i), int'(tap_out), exp);
         if (int'(tap_out) != et && int'(tap_out) != upper_of(et)) bad++;
         if (is_upper(i, em)) begin
            ups++;
            if (first < 0) first = i;
            if (prevp >= 0) begin
               if (i - prevp < gmin) gmin = i - prevp;
               if (i - prevp > gmax) gmax = i - prevp;
            end
            prevp = i;
         end
         if (mid && i == 10) begin tap_in = 5'(mt); mod_in = 5'(mm); end
         if (i == 31) begin tap_in = 5'(nt); mod_in = 5'(nm); end
         @(negedge clk);
      end
      // expected-count check uses the observed output, counted against the base tap
      begin
         int seen = 0;
         for (int i = 0; i < 32; i++) if (last_pat[i] != et) seen++;
         check(seen == ((et == 31) ? 0 : em), "R2", "upper-tap cycles in frame",
               seen, (et == 31) ? 0 : em);
      end
      check(bad == 0, "R8", "cycles off the two allowed taps", bad, 0);
      if (em >= 2) begin
         int wrap = first + 32 - prevp;
         if (wrap < gmin) gmin = wrap;
         if (wrap > gmax) gmax = wrap;
         check(gmax - gmin <= 1, "R4", "gap spread across frame", gmax - gmin, 1);
      end
      if (ups != em) check(1'b0, "R2", "bench model count", ups, em);
   endtask

   task automatic t_reset_state();
      do_reset(7, 9);
      run_frame(7, 9, 7, 9, 1'b0, 0, 0, "R7");
   endtask

   task automatic t_repeat();
      int diff = 0;
      for (int i = 0; i < 32; i++) prev_pat[i] = last_pat[i];
      run_frame(7, 9, 3, 0, 1'b0, 0, 0, "R1");
      for (int i = 0; i < 32; i++) if (prev_pat[i] != last_pat[i]) diff++;
      check(diff == 0, "R1", "cycles differing between frames", diff, 0);
   endtask

   task automatic t_zero_mod();
      run_frame(3, 0, 12, 1, 1'b0, 0, 0, "R3");
   endtask

   task automatic t_spread();
      run_frame(12, 1, 5, 16, 1'b0, 0, 0, "R4");
      run_frame(5, 16, 0, 31, 1'b0, 0, 0, "R4");
      run_frame(0, 31, 30, 13, 1'b0, 0, 0, "R4");
      run_frame(30, 13, 31, 20, 1'b0, 0, 0, "R4");
   endtask

   task automatic t_clamp();
      run_frame(31, 20, 31, 31, 1'b0, 0, 0, "R5");
      run_frame(31, 31, 4, 5, 1'b0, 0, 0, "R5");
   endtask

   task automatic t_midframe();
      run_frame(4, 5, 20, 27, 1'b1, 18, 2, "R6");
      run_frame(20, 27, 9, 3, 1'b0, 0, 0, "R6");
   endtask

   task automatic t_reset_mid();
      repeat (12) @(negedge clk);
      do_reset(14, 22);
      run_frame(14, 22, 14, 22, 1'b0, 0, 0, "R7");
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      mismatched++;
      $display("FAIL R1 watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      t_reset_state();
      t_repeat();
      t_zero_mod();
      t_spread();
      t_clamp();
      t_midframe();
      t_reset_mid();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule